// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recent virtual-to-physical page mappings and answers a translation request in the same cycle it is presented. A requester gives a virtual page number, a page offset and an access kind. If a valid entry matches and its permission bits allow the access, the block reports a hit, forms the physical address from the cached physical page number and the offset, and returns the entry's permission bits. If the entry forbids the access, the block raises a protection fault. In every other case it reports a miss.

After a miss, an external table walker fetches the mapping and installs it through the fill port, and the requester then retries. A fill goes to an entry that already holds the same page number if there is one. Otherwise it goes to an invalid entry, and failing that to the least recently used entry. The cache never writes anything back. A write to an entry whose dirty bit is clear is reported as a miss, so the walker can mark the page dirty in memory and refill the entry. A full flush is used when the page table base changes. A single-entry invalidate is used when one table entry is edited.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, and every lookup reports neither hit nor fault.
- R2: A lookup whose page number matches a valid entry, and which is permitted, reports a hit in the same cycle. The output address is the cached physical page number concatenated above the unchanged offset, and the entry's permission field is returned.
- R3: The permission field is {dirty, exec, write, read} at bits 3..0. The access kind is 0 for read, 1 for write, 2 for exec and 3 for read. A matching lookup whose required bit is clear reports a fault and no hit. Hit and fault are never both high.
- R4: A write lookup on a matching entry that has the write bit set and the dirty bit clear reports neither hit nor fault. The same lookup on an entry with the dirty bit set hits.
- R5: A fill goes to an entry holding the same page number if one exists. Otherwise it goes to an invalid entry. Otherwise it goes to the least recently used entry.
- R6: An entry becomes most recently used when it is filled, or when it hits in a cycle without a fill or flush. The next fill into a full cache replaces the entry touched longest ago.
- R7: A flush invalidates every entry in one cycle. It takes priority over a fill or an invalidate in the same cycle, so that fill is dropped.
- R8: An invalidate clears the entry holding the given page number and leaves the others intact. If a fill of the same page number arrives in the same cycle, the entry ends up invalid.
- R9: Refilling a cached page number overwrites the existing entry in place, so no page number is ever held by two entries.
- R10: A miss or a fault leaves the recency order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_kind | input | 2 | Access kind (0 read, 1 write, 2 exec, 3 read) |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_off | input | OFF_W | Page offset |
| lk_hit | output | 1 | Translation valid and permitted |
| lk_fault | output | 1 | Matching entry forbids the access |
| lk_paddr | output | PPN_W+OFF_W | Physical address on a hit |
| lk_perm | output | 4 | Permission field of the matching entry, 0 if none |
| fill_valid | input | 1 | Install a mapping |
| fill_vpn | input | VPN_W | Page number of the installed mapping |
| fill_ppn | input | PPN_W | Physical page number of the installed mapping |
| fill_perm | input | 4 | Permission field of the installed mapping |
| inv_valid | input | 1 | Invalidate one page number |
| inv_vpn | input | VPN_W | Page number to invalidate |
| flush_all | input | 1 | Invalidate every entry |

## Verification
Recency is the hardest state to reach from the ports. It only shows when a fill lands in a full cache, and every lookup that hits changes it. The bench keeps a timestamp-per-entry model, which works differently from the design's age ranks. It runs a small four-entry build through directed sequences that fill all entries, touch a chosen subset, and then force an eviction. A long random stream over only eight page numbers keeps the cache full and mixes fills, invalidates and flushes with lookups in the same cycles. This reaches the tie cases of R7, R8 and R9 many times.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PERM_W   = 4;
  localparam int PB_READ  = 0;
  localparam int PB_WRITE = 1;
  localparam int PB_EXEC  = 2;
  localparam int PB_DIRTY = 3;

  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_EXEC  = 2'd2;

  // permission bit that an access kind needs; kind 3 acts as read
  function automatic logic perm_allows(input logic [PERM_W-1:0] p, input logic [1:0] kind);
    case (kind)
      KIND_WRITE: perm_allows = p[PB_WRITE];
      KIND_EXEC:  perm_allows = p[PB_EXEC];
      default:    perm_allows = p[PB_READ];
    endcase
  endfunction

  // a write to a clean page must go back to the walker
  function automatic logic needs_dirty(input logic [PERM_W-1:0] p, input logic [1:0] kind);
    needs_dirty = (kind == KIND_WRITE) && !p[PB_DIRTY];
  endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N     = 64,
  parameter int VPN_W = 20,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]        key,
  output logic [N-1:0]            hits,
  output logic                    any,
  output logic [IDX_W-1:0]        idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = valid[g] && (tags[g] == key);
  end

  assign any = |hits;

  // hits is one-hot at most, so OR-ing indices encodes it
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (hits[i]) idx = idx | IDX_W'(i);
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  // each entry holds a rank; 0 is newest, N-1 is oldest; ranks form a permutation
  logic [N-1:0][IDX_W-1:0] rank_q;
  logic [N-1:0]            is_oldest;
  logic [IDX_W-1:0]        touched_rank;

  assign touched_rank = rank_q[touch_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx)         rank_q[i] <= '0;
        else if (rank_q[i] < touched_rank)  rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign is_oldest[g] = (rank_q[g] == IDX_W'(N - 1));
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++)
      if (is_oldest[i]) victim_idx = victim_idx | IDX_W'(i);
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_oldest) == 1); // R6
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [1:0]             lk_kind,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFF_W-1:0]       lk_off,
  output logic                   lk_hit,
  output logic                   lk_fault,
  output logic [PPN_W+OFF_W-1:0] lk_paddr,
  output logic [3:0]             lk_perm,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic [3:0]             fill_perm,
  input  logic                   inv_valid,
  input  logic [VPN_W-1:0]       inv_vpn,
  input  logic                   flush_all
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]              valid_q, valid_d;
  logic [ENTRIES-1:0][VPN_W-1:0]   tag_q, tag_d;
  logic [ENTRIES-1:0][PPN_W-1:0]   ppn_q, ppn_d;
  logic [ENTRIES-1:0][PERM_W-1:0]  perm_q, perm_d;

  // ---------------- lookup path ----------------
  logic [ENTRIES-1:0] lk_hits;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;
  logic [PERM_W-1:0]  sel_perm;
  logic               sel_allowed;

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
    .valid(valid_q), .tags(tag_q), .key(lk_vpn),
    .hits(lk_hits), .any(lk_any), .idx(lk_idx)
  );

  assign sel_perm    = perm_q[lk_idx];
  assign sel_allowed = perm_allows(sel_perm, lk_kind);
  assign lk_fault    = lk_valid && lk_any && !sel_allowed;
  assign lk_hit      = lk_valid && lk_any && sel_allowed && !needs_dirty(sel_perm, lk_kind);
  assign lk_paddr    = {ppn_q[lk_idx], lk_off};
  assign lk_perm     = lk_any ? sel_perm : '0;

  // ---------------- fill placement ----------------
  logic [ENTRIES-1:0] fill_hits;
  logic               fill_any;
  logic [IDX_W-1:0]   fill_idx;
  logic               has_free;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   fill_slot;

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_fill_match (
    .valid(valid_q), .tags(tag_q), .key(fill_vpn),
    .hits(fill_hits), .any(fill_any), .idx(fill_idx)
  );

  // lowest-numbered invalid entry
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  assign fill_slot = fill_any ? fill_idx : (has_free ? free_idx : victim_idx);

  // named events for assertions
  logic ev_fill, ev_touch;
  logic [IDX_W-1:0] touch_idx;
  assign ev_fill   = fill_valid && !flush_all;
  assign ev_touch  = ev_fill || (lk_hit && !flush_all);
  assign touch_idx = ev_fill ? fill_slot : lk_idx;

  xlat_lru #(.N(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(ev_touch),
    .touch_idx(touch_idx), .victim_idx(victim_idx)
  );

  // ---------------- next state ----------------
  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    ppn_d   = ppn_q;
    perm_d  = perm_q;
    if (ev_fill) begin
      valid_d[fill_slot] = 1'b1;
      tag_d[fill_slot]   = fill_vpn;
      ppn_d[fill_slot]   = fill_ppn;
      perm_d[fill_slot]  = fill_perm;
    end
    // invalidate acts on the post-fill contents
    if (inv_valid)
      for (int i = 0; i < ENTRIES; i++)
        if (tag_d[i] == inv_vpn) valid_d[i] = 1'b0;
    if (flush_all) valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      ppn_q   <= '0;
      perm_q  <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      ppn_q   <= ppn_d;
      perm_q  <= perm_d;
    end
  end

  // ---------------- assertions ----------------
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_q == '0)); // R1
  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault)); // R3
  AST_CLEAN_WRITE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind == KIND_WRITE && !lk_perm[PB_DIRTY]) |-> !lk_hit); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0)); // R7
  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hits) && $onehot0(fill_hits)); // R9
  for (genvar g = 0; g < ENTRIES; g++) begin : g_inv_chk
    AST_INV_GONE: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |=> !(valid_q[g] && tag_q[g] == $past(inv_vpn))); // R8
  end
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, fill_valid = 0, inv_valid = 0, flush_all = 0;
  logic [1:0]  lk_kind = 0;
  logic [19:0] lk_vpn = 0, fill_vpn = 0, fill_ppn = 0, inv_vpn = 0;
  logic [11:0] lk_off = 0;
  logic [3:0]  fill_perm = 0;
  logic        lk_hit, lk_fault;
  logic [31:0] lk_paddr;
  logic [3:0]  lk_perm;

  always #5 clk = ~clk;

  xlat_cache #(.ENTRIES(NE), .VPN_W(20), .PPN_W(20), .OFF_W(12)) u_xlat_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush_all(flush_all)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model: timestamp per entry, lowest stamp is least recent
  bit          m_v [NE];
  logic [19:0] m_t [NE];
  logic [19:0] m_p [NE];
  logic [3:0]  m_r [NE];
  int          m_s [NE];
  int          now = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  function automatic int m_find(input logic [19:0] v);
    for (int i = 0; i < NE; i++) if (m_v[i] && m_t[i] == v) return i;
    return -1;
  endfunction

  function automatic bit need_bit(input logic [3:0] p, input logic [1:0] k);
    if (k == 2'd1) return p[1];
    if (k == 2'd2) return p[2];
    return p[0];
  endfunction

  task automatic step(input bit le, input logic [1:0] k, input logic [19:0] v, input logic [11:0] off,
                      input bit fe, input logic [19:0] fv, input logic [19:0] fp, input logic [3:0] fr,
                      input bit ie, input logic [19:0] iv, input bit fl, input string tag,
                      output bit got_hit, output bit got_fault);
    int idx, slot, best;
    bit e_hit, e_fault;
    @(negedge clk);
    lk_valid = le; lk_kind = k; lk_vpn = v; lk_off = off;
    fill_valid = fe; fill_vpn = fv; fill_ppn = fp; fill_perm = fr;
    inv_valid = ie; inv_vpn = iv; flush_all = fl;
    #1;
    idx = le ? m_find(v) : -1;
    e_fault = (idx >= 0) && !need_bit(m_r[idx], k);
    e_hit   = (idx >= 0) && !e_fault && !(k == 2'd1 && !m_r[idx][3]);
    got_hit = lk_hit; got_fault = lk_fault;
    if (le) begin
      chk(lk_hit === e_hit, tag, "hit", 32'(lk_hit), 32'(e_hit));
      chk(lk_fault === e_fault, tag, "fault", 32'(lk_fault), 32'(e_fault));
      if (e_hit) begin
        chk(lk_paddr === {m_p[idx], off}, tag, "paddr", lk_paddr, {m_p[idx], off});
        chk(lk_perm === m_r[idx], tag, "perm", 32'(lk_perm), 32'(m_r[idx]));
      end
    end
    now++;
    if (fl) begin
      for (int i = 0; i < NE; i++) m_v[i] = 0;
    end else begin
      if (fe) begin
        slot = m_find(fv);
        if (slot < 0)
          for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) slot = i;
        if (slot < 0) begin
          best = 0;
          for (int i = 1; i < NE; i++) if (m_s[i] < m_s[best]) best = i;
          slot = best;
        end
        m_v[slot] = 1; m_t[slot] = fv; m_p[slot] = fp; m_r[slot] = fr; m_s[slot] = now;
      end else if (e_hit) begin
        m_s[idx] = now;
      end
      if (ie)
        for (int i = 0; i < NE; i++) if (m_v[i] && m_t[i] == iv) m_v[i] = 0;
    end
    @(posedge clk);
    #1;
    lk_valid = 0; fill_valid = 0; inv_valid = 0; flush_all = 0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] r, input string tag);
    bit h, f;
    step(0, 0, 0, 0, 1, v, p, r, 0, 0, 0, tag, h, f);
  endtask

  task automatic probe(input logic [19:0] v, input logic [1:0] k, input bit eh, input bit ef,
                       input string tag);
    bit h, f;
    step(1, k, v, 12'h3c5, 0, 0, 0, 0, 0, 0, 0, tag, h, f);
    chk(h == eh, tag, "literal hit", 32'(h), 32'(eh));
    chk(f == ef, tag, "literal fault", 32'(f), 32'(ef));
  endtask

  task automatic ctl(input bit fe, input logic [19:0] fv, input bit ie, input logic [19:0] iv,
                     input bit fl, input string tag);
    bit h, f;
    step(0, 0, 0, 0, fe, fv, 20'h0beef, 4'hf, ie, iv, fl, tag, h, f);
  endtask

  localparam logic [19:0] VA = 20'h10001, VB = 20'h10002, VC = 20'h10003,
                          VD = 20'h10004, VE = 20'h10005;

  initial begin
    bit h, f;
    for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_t[i] = 0; m_p[i] = 0; m_r[i] = 0; m_s[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    probe(VA, 0, 0, 0, "R1");
    probe(20'h00000, 1, 0, 0, "R1");
    probe(20'hfffff, 2, 0, 0, "R1");

    // R2: translation and address forming
    fill(VA, 20'h0a0a0, 4'hf, "R2");
    fill(VB, 20'hfffff, 4'hf, "R2");
    for (int o = 0; o < 4096; o += 273) step(1, 0, VA, 12'(o), 0, 0, 0, 0, 0, 0, 0, "R2", h, f);
    for (int o = 1; o < 4096; o += 511) step(1, 2, VB, 12'(o), 0, 0, 0, 0, 0, 0, 0, "R2", h, f);

    // R3: permission sweep over all fields and kinds
    for (int p = 0; p < 16; p++)
      for (int k = 0; k < 4; k++) begin
        fill(VC, 20'(p * 4099), 4'(p), "R3");
        step(1, 2'(k), VC, 12'(p), 0, 0, 0, 0, 0, 0, 0, "R3", h, f);
      end

    // R4 and R9: clean write misses, dirty refill in place
    ctl(0, 0, 0, 0, 1, "R7");
    fill(VA, 20'h00111, 4'b0011, "R4");
    probe(VA, 1, 0, 0, "R4");
    probe(VA, 0, 1, 0, "R4");
    fill(VA, 20'h00222, 4'b1011, "R9");
    probe(VA, 1, 1, 0, "R4");
    fill(VB, 20'h00333, 4'hf, "R9");
    fill(VC, 20'h00444, 4'hf, "R9");
    fill(VD, 20'h00555, 4'hf, "R9");
    probe(VA, 0, 1, 0, "R9");
    probe(VB, 0, 1, 0, "R9");
    probe(VC, 0, 1, 0, "R9");
    probe(VD, 0, 1, 0, "R9");

    // R5/R6: recency decides the victim
    ctl(0, 0, 0, 0, 1, "R7");
    fill(VA, 20'h00a00, 4'hf, "R5");
    fill(VB, 20'h00b00, 4'hf, "R5");
    fill(VC, 20'h00c00, 4'hf, "R5");
    fill(VD, 20'h00d00, 4'hf, "R5");
    probe(VA, 0, 1, 0, "R6");
    probe(VC, 0, 1, 0, "R6");
    probe(VD, 0, 1, 0, "R6");
    fill(VE, 20'h00e00, 4'hf, "R6");
    probe(VB, 0, 0, 0, "R6");
    probe(VA, 0, 1, 0, "R6");
    probe(VE, 0, 1, 0, "R5");

    // R10: a fault does not refresh recency
    ctl(0, 0, 0, 0, 1, "R7");
    fill(VA, 20'h00a01, 4'b0001, "R10");
    fill(VB, 20'h00b01, 4'hf, "R10");
    fill(VC, 20'h00c01, 4'hf, "R10");
    fill(VD, 20'h00d01, 4'hf, "R10");
    probe(VA, 2, 0, 1, "R10");
    probe(VE, 0, 0, 0, "R10");
    fill(VE, 20'h00e01, 4'hf, "R10");
    probe(VA, 0, 0, 0, "R10");
    probe(VB, 0, 1, 0, "R10");

    // R7: flush beats a fill in the same cycle
    ctl(1, VA, 0, 0, 1, "R7");
    probe(VA, 0, 0, 0, "R7");
    probe(VB, 0, 0, 0, "R7");

    // R8: single invalidate
    fill(VA, 20'h01a00, 4'hf, "R8");
    fill(VB, 20'h01b00, 4'hf, "R8");
    ctl(0, 0, 1, VA, 0, "R8");
    probe(VA, 0, 0, 0, "R8");
    probe(VB, 0, 1, 0, "R8");
    ctl(1, VC, 1, VC, 0, "R8");
    probe(VC, 0, 0, 0, "R8");
    ctl(1, VD, 1, VB, 0, "R8");
    probe(VB, 0, 0, 0, "R8");
    probe(VD, 0, 1, 0, "R8");

    // random mix over eight page numbers
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = int'($urandom_range(0, 63));
      step(1, 2'($urandom_range(0, 3)), 20'h5a000 | 20'($urandom_range(0, 7)), 12'($urandom),
           op < 28, 20'h5a000 | 20'($urandom_range(0, 7)), 20'($urandom), 4'($urandom),
           op >= 24 && op < 36, 20'h5a000 | 20'($urandom_range(0, 7)), op == 63,
           "R5", h, f);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule